// File: doc/BRIEF.md
# Serial Packet Line Encoder with Bit Stuffing and NRZI

This block is the transmit side of a full-speed serial link of the USB kind. A packet arrives as a stream of bytes on a valid/ready handshake, and a flag marks the final byte. The encoder emits one line bit per bit-clock strobe. It starts every packet with a synchronization byte that it supplies itself. It then shifts out each payload byte starting from bit 0. After each run of six ones it inserts a zero. Every bit is NRZI coded: a one holds the line level and a zero flips it.

The packet closes with a short end marker. For two bit times a separate flag is high while the line is parked at the idle level. Output-enable frames the whole transmission. When the encoder inserts a zero it stalls the byte source by one bit time. The NRZI level carries on without a break through the sync bits, the payload bits and the stuffed bits.

Top module: `usb_nrzi_tx`

## Requirements
- R1: A line bit of 1 leaves `line_out` unchanged and a line bit of 0 inverts it. At the first sync bit the level starts from the idle level 1, so the first sync bit drives `line_out` to 0.
- R2: Each packet first sends the byte 80h, then the accepted bytes in the order they were accepted. Every byte goes out from bit 0 to bit 7.
- R3: After six consecutive 1 bits of unencoded stream, one extra 0 bit is emitted before the next bit. The run counter restarts on every 0, stuffed zeros included, and starts from zero at the first sync bit.
- R4: If the last payload bit completes a run of six ones, a stuffed 0 is still emitted before the end marker.
- R5: `in_ready` is high only in a cycle with `bit_en` high, when the bit being emitted is bit 7 of a byte that is not the final byte and is not a stuffed bit. Each byte is taken exactly once, on a cycle where `in_valid` and `in_ready` are both high.
- R6: Outputs change only on cycles where `bit_en` is high, one line bit per strobe.
- R7: After the final bit, and after any stuffed bit that follows it, `eop_flag` is 1 for exactly two strobes. During those strobes `line_out` is 1 and `line_oe` is 1. On the next strobe both `line_oe` and `eop_flag` fall to 0.
- R8: While reset is held and while idle, `line_out` is 1, `line_oe` is 0, `eop_flag` is 0 and `in_ready` is 0. An idle encoder starts a packet on the first strobe that finds `in_valid` high.
- R9: If `in_valid` is low when bit 7 of a non-final byte is emitted, that byte is treated as the final byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-time strobe, one line bit per high cycle |
| in_data | input | 8 | Packet byte offered by the source |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | The offered byte is the final byte of the packet |
| in_ready | output | 1 | Byte taken this cycle when `in_valid` is also high |
| line_out | output | 1 | NRZI-coded single-ended line level |
| line_oe | output | 1 | Line driver enable, high from the first sync bit through the end marker |
| eop_flag | output | 1 | End-marker indication, high for two bit times |

## Verification
A wrong NRZI level or a bad run count shows on `line_out` within the bit time where it goes wrong. Because NRZI carries its level forward, such an error also inverts every later level until the packet ends, so it is seen at the first strobe after it. A byte that is skipped or taken twice shifts the whole remaining bit stream. It also changes the number of handshakes counted over the packet. A fault in ending the packet moves the end marker or the fall of `line_oe` by whole bit times.

// File: rtl/usb_nrzi_tx.sv
module usb_nrzi_tx #(
  parameter int STUFF_LEN = 6,
  parameter int EOP_LEN   = 2,
  parameter logic [7:0] SYNC_PAT = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       line_out,
  output logic       line_oe,
  output logic       eop_flag
);
  localparam int RW = $clog2(STUFF_LEN + 1);
  localparam int EW = $clog2(EOP_LEN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_LEN);
  localparam logic [EW-1:0] EOP_MAX = EW'(EOP_LEN);

  logic [7:0]    shreg_q;
  logic [2:0]    bitcnt_q;
  logic [RW-1:0] ones_q;
  logic [EW-1:0] ecnt_q;
  logic          busy_q, empty_q, lastb_q;

  wire stuff_now = (ones_q == RUN_MAX);
  wire cur_bit   = shreg_q[bitcnt_q];
  wire take      = in_ready & in_valid;

  assign in_ready = bit_en & busy_q & ~empty_q & ~stuff_now & (bitcnt_q == 3'd7) & ~lastb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_out <= 1'b1;
      line_oe  <= 1'b0;
      eop_flag <= 1'b0;
      busy_q   <= 1'b0;
      empty_q  <= 1'b0;
      lastb_q  <= 1'b0;
      ones_q   <= '0;
      ecnt_q   <= '0;
      bitcnt_q <= '0;
      shreg_q  <= '0;
    end else if (bit_en) begin
      if (ecnt_q != '0) begin
        line_out <= 1'b1;
        if (ecnt_q == EOP_MAX) begin
          ecnt_q   <= '0;
          eop_flag <= 1'b0;
          line_oe  <= 1'b0;
        end else begin
          ecnt_q <= ecnt_q + 1'b1;
        end
      end else if (!busy_q) begin
        if (in_valid) begin
          busy_q   <= 1'b1;
          empty_q  <= 1'b0;
          lastb_q  <= 1'b0;
          line_oe  <= 1'b1;
          shreg_q  <= SYNC_PAT;
          line_out <= SYNC_PAT[0] ? line_out : ~line_out;
          ones_q   <= SYNC_PAT[0] ? RW'(1) : '0;
          bitcnt_q <= 3'd1;
        end
      end else if (stuff_now) begin
        line_out <= ~line_out;
        ones_q   <= '0;
      end else if (empty_q) begin
        busy_q   <= 1'b0;
        empty_q  <= 1'b0;
        eop_flag <= 1'b1;
        line_out <= 1'b1;
        ecnt_q   <= EW'(1);
      end else begin
        line_out <= cur_bit ? line_out : ~line_out;
        ones_q   <= cur_bit ? ones_q + 1'b1 : '0;
        if (bitcnt_q == 3'd7) begin
          bitcnt_q <= '0;
          if (take) begin
            shreg_q <= in_data;
            lastb_q <= in_last;
          end else begin
            empty_q <= 1'b1;
          end
        end else begin
          bitcnt_q <= bitcnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/usb_nrzi_tx_chk.sv
module usb_nrzi_tx_chk #(
  parameter int STUFF_LEN = 6,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          in_ready,
  input logic          line_out,
  input logic          line_oe,
  input logic          eop_flag,
  input logic [RW-1:0] run_len
);
  // R5
  ready_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_en);
  // R5
  stuff_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_len == RW'(STUFF_LEN)) |-> !in_ready);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(line_out) && $stable(line_oe) && $stable(eop_flag)));
  // R7
  eop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eop_flag |-> (line_oe && line_out));
  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> (line_out && !eop_flag && !in_ready));
  // R1
  first_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !line_out);
  // R3
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RW'(STUFF_LEN));
endmodule

bind usb_nrzi_tx usb_nrzi_tx_chk #(.STUFF_LEN(STUFF_LEN), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_ready(in_ready),
  .line_out(line_out), .line_oe(line_oe), .eop_flag(eop_flag), .run_len(ones_q)
);

// File: tb/usb_nrzi_tx_tb.sv
module usb_nrzi_tx_tb_top;
  logic clk = 1'b0;
  logic rst_n, bit_en, in_valid, in_last, in_ready, line_out, line_oe, eop_flag;
  logic [7:0] in_data;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  usb_nrzi_tx dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .line_out(line_out), .line_oe(line_oe), .eop_flag(eop_flag)
  );

  logic [7:0] pkt [16];
  int pn;
  bit plast;
  logic el [512], eo [512], ee [512];
  int en;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rec(input logic l, input logic o, input logic e);
    el[en] = l; eo[en] = o; ee[en] = e; en++;
  endtask

  task automatic build();
    logic lvl;
    int ones;
    logic [7:0] b;
    en = 0; lvl = 1'b1; ones = 0;
    for (int j = 0; j <= pn; j++) begin
      b = (j == 0) ? 8'h80 : pkt[j-1];
      for (int i = 0; i < 8; i++) begin
        if (!b[i]) lvl = ~lvl;
        rec(lvl, 1'b1, 1'b0);
        ones = b[i] ? ones + 1 : 0;
        if (ones == 6) begin
          lvl = ~lvl;
          rec(lvl, 1'b1, 1'b0);
          ones = 0;
        end
      end
    end
    rec(1'b1, 1'b1, 1'b1);
    rec(1'b1, 1'b1, 1'b1);
    rec(1'b1, 1'b0, 1'b0);
  endtask

  task automatic run_pkt(input int gap);
    int idx = 0, k = 0, acc = 0, ph = 0;
    bit hs = 0, sp = 0;
    logic held;
    build();
    held = line_out;
    while (k < en) begin
      @(negedge clk);
      if (sp) begin
        chk(line_out == el[k], "R1 R2 R3 R4 line_out", line_out, el[k]);
        chk(line_oe == eo[k], "R7 R8 line_oe", line_oe, eo[k]);
        chk(eop_flag == ee[k], "R7 eop_flag", eop_flag, ee[k]);
        k++;
      end else begin
        chk(line_out == held, "R6 hold", line_out, held);
      end
      held = line_out;
      if (hs) idx++;
      ph = (ph + 1) % gap;
      bit_en = (ph == 0) && (k < en);
      in_valid = idx < pn;
      in_data = (idx < pn) ? pkt[idx] : 8'h00;
      in_last = plast && (idx == pn - 1);
      #1;
      if (in_ready && !bit_en) chk(1'b0, "R5 ready without strobe", 1, 0);
      hs = in_ready && in_valid;
      if (hs) acc++;
      sp = bit_en;
    end
    @(negedge clk);
    bit_en = 0; in_valid = 0; in_last = 0;
    chk(acc == pn, "R5 R9 bytes taken", acc, pn);
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 0; bit_en = 0; in_valid = 0; in_last = 0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    bit_en = 1; in_valid = 1;
    @(negedge clk);
    // R8 reset state, strobe and valid held during reset
    chk(line_out == 1'b1, "R8 reset line_out", line_out, 1);
    chk(line_oe == 1'b0, "R8 reset line_oe", line_oe, 0);
    chk(eop_flag == 1'b0, "R8 reset eop_flag", eop_flag, 0);
    chk(in_ready == 1'b0, "R8 reset in_ready", in_ready, 0);
    bit_en = 0; in_valid = 0;
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R8 idle without valid: strobes do nothing
    bit_en = 1;
    repeat (3) @(negedge clk);
    chk(line_oe == 1'b0 && line_out == 1'b1, "R8 idle", {line_oe, line_out}, 1);
    bit_en = 0;
    // R1 R2 R3: every single-byte packet
    pn = 1; plast = 1;
    for (int v = 0; v < 256; v++) begin
      pkt[0] = 8'(v);
      run_pkt(1);
    end
    // R3: long runs of ones
    pn = 3; plast = 1; pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFF;
    run_pkt(3);
    // R4: six ones end on the last bit
    pn = 2; plast = 1; pkt[0] = 8'hE1; pkt[1] = 8'hFC;
    run_pkt(2);
    pn = 4; plast = 1; pkt[0] = 8'h3F; pkt[1] = 8'h7E; pkt[2] = 8'h00; pkt[3] = 8'hFF;
    run_pkt(3);
    // R9: source runs dry without a last flag
    pn = 2; plast = 0; pkt[0] = 8'hD2; pkt[1] = 8'h7F;
    run_pkt(2);
    // R2 R5: longer packet
    pn = 16; plast = 1;
    for (int i = 0; i < 16; i++) pkt[i] = 8'(i * 37 + 5);
    run_pkt(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule